// File: doc/BRIEF.md
# Four-Lane Serial Bias DAC Loader with Echo Verification

This block programs 32 bias-voltage codes into four serial DACs that hang off separate data, select and feedback lines but share one serial clock. A single-cycle start command makes it copy the codes from a host-writable register bank into a local buffer, one entry per clock. It then streams one frame to every DAC at the same time. While it shifts, it samples the bits each DAC echoes back and compares them with the bits it sent.

Each DAC frame opens with a fixed control word, carries eight channel codes and ends with one padding slot. The padding slot lets the echo of the last code bit come back. At the end the block reports a busy flag, a loaded flag and an error flag, plus one pass bit per channel, split over two 16-bit words. The serial clock only runs while a frame is in flight. Between commands the divider is held and the clock line stays low.

Top module: `hvl_dac_loader`

## Requirements
- R1: After reset and whenever no command is in progress, busy_o, loaded_o and error_o are 0, all cs_n_o lines are 1 and sclk_o is 0. Both pass words are 0 after reset.
- R2: A start_i pulse seen while idle raises busy_o on the next cycle. busy_o then stays high for exactly 1 + 36 + 91*DIV cycles, which is 765 with DIV = 8. A start_i pulse while busy_o is high is ignored and changes neither the duration nor the results.
- R3: Channel c (0..31) is read from bank word rd_addr_o = c during the fill phase. Channel c is sent to DAC c/8 as code word c%8 + 1 of that DAC's frame. Changing the bank after the fill phase has no effect on the data sent.
- R4: Each DAC frame has 91 bit slots. First come the 10-bit HDR_WORD, then the eight 10-bit codes taken from rd_data_i[9:0], each sent MSB first, then one slot carrying 0. Bits 15:10 of rd_data_i are ignored. mosi_o is 0 outside a frame.
- R5: A bit slot lasts DIV clocks. sclk_o is low for the first DIV/2 clocks of a slot and high for the rest. mosi_o changes only at a slot boundary and is stable while sclk_o is high. All four cs_n_o lines are low from the first slot of the frame to the end of the padding slot, and they go low 36 cycles after the cycle busy_o rises.
- R6: The feedback line of each DAC is taken to return every received bit one slot later. The pass bit of a channel is 1 only if all ten echoed bits of its code equal the bits sent.
- R7: pass_lo_o bit c holds channel c for c < 16, and pass_hi_o bit c-16 holds channel c for c >= 16.
- R8: loaded_o rises in the cycle busy_o falls. error_o is raised at the same time if any pass bit is 0 or any DAC's echoed control word differs from HDR_WORD.
- R9: In the cycle busy_o rises, the pass bits, loaded_o and error_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle load command |
| rd_en_o | output | 1 | Bank read strobe during fill |
| rd_addr_o | output | 5 | Bank channel index being read |
| rd_data_i | input | 16 | Bank word, combinational on rd_addr_o |
| sclk_o | output | 1 | Shared serial clock |
| cs_n_o | output | 4 | Per-DAC active-low select |
| mosi_o | output | 4 | Per-DAC serial data out |
| miso_i | input | 4 | Per-DAC echoed serial data |
| busy_o | output | 1 | Command in progress |
| loaded_o | output | 1 | Last command finished |
| error_o | output | 1 | Last command saw a mismatch |
| pass_lo_o | output | 16 | Pass bits, channels 0..15 |
| pass_hi_o | output | 16 | Pass bits, channels 16..31 |

## Verification
The properties take for granted that start_i is a clean single-cycle pulse and that rd_data_i settles in the same cycle as rd_addr_o. They also assume each feedback line changes only while the serial clock is low, one slot behind the data. In the bench, every DAC model updates its echo on the falling serial clock edge it sees. The bank stays constant from the accepted start until the fill phase ends. Echo faults are injected as single inverted bits, including the last bit of a code word and a bit of the control word.

// File: rtl/hvl_pkg.sv
package hvl_pkg;
    localparam int NDAC   = 4;
    localparam int CPD    = 8;
    localparam int CODE_W = 10;
    localparam int REG_W  = 16;
    localparam int NCH    = NDAC * CPD;
    localparam int WPD    = CPD + 1;
    localparam int NENT   = NDAC * WPD;
    localparam int NSLOT  = WPD * CODE_W + 1;
    localparam int ADDR_W = $clog2(NCH);
    localparam int DAC_W  = $clog2(NDAC);
    localparam int WIDX_W = $clog2(WPD + 2);
    localparam int BIT_W  = $clog2(CODE_W);

    typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_SHIFT, ST_DONE} hvl_st_e;

    typedef struct packed {
        hvl_st_e                        st;
        logic [DAC_W-1:0]               fd;
        logic [WIDX_W-1:0]              fw;
        logic [WIDX_W-1:0]              word;
        logic [BIT_W-1:0]               bitp;
        logic                           cs_n;
        logic                           busy;
        logic                           loaded;
        logic                           err;
        logic [NCH-1:0]                 pass;
        logic [NDAC-1:0]                hdr_ok;
        logic [NENT-1:0][CODE_W-1:0]    mem;
    } hvl_ctl_t;
endpackage

// File: rtl/hvl_sclk_div.sv
module hvl_sclk_div #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic smp_o,
    output logic adv_o
);
    localparam int DC_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [DC_W-1:0] HALF_M1 = DC_W'(DIV / 2 - 1);
    localparam logic [DC_W-1:0] LAST    = DC_W'(DIV - 1);

    typedef struct packed {
        logic [DC_W-1:0] dc;
        logic            sclk;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (!run_i) begin
            div_d.dc   = '0;
            div_d.sclk = 1'b0;
        end else begin
            div_d.dc = (div_q.dc == LAST) ? '0 : div_q.dc + 1'b1;
            if (div_q.dc == HALF_M1) div_d.sclk = 1'b1;
            if (div_q.dc == LAST)    div_d.sclk = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign sclk_o = div_q.sclk;
    assign smp_o  = run_i && (div_q.dc == HALF_M1);
    assign adv_o  = run_i && (div_q.dc == LAST);
endmodule

// File: rtl/hvl_lane.sv
module hvl_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic first_i,
    input  logic adv_i,
    input  logic nxt_i,
    input  logic smp_i,
    input  logic end_i,
    input  logic fb_i,
    output logic sdo_o,
    output logic ok_o
);
    typedef struct packed {
        logic sdo;
        logic prev;
        logic ok;
    } lane_t;

    lane_t ln_d, ln_q;

    assign ok_o  = ln_q.ok & (fb_i == ln_q.prev);
    assign sdo_o = ln_q.sdo;

    always_comb begin
        ln_d = ln_q;
        if (load_i) begin
            ln_d.sdo  = first_i;
            ln_d.prev = 1'b0;
            ln_d.ok   = 1'b1;
        end else begin
            if (adv_i) begin
                ln_d.prev = ln_q.sdo;
                ln_d.sdo  = nxt_i;
            end
            if (smp_i) ln_d.ok = end_i ? 1'b1 : ok_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end
endmodule

// File: rtl/hvl_dac_loader.sv
module hvl_dac_loader
    import hvl_pkg::*;
#(
    parameter int                 DIV      = 8,
    parameter logic [CODE_W-1:0]  HDR_WORD = 10'h2A5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    output logic                 rd_en_o,
    output logic [ADDR_W-1:0]    rd_addr_o,
    input  logic [REG_W-1:0]     rd_data_i,
    output logic                 sclk_o,
    output logic [NDAC-1:0]      cs_n_o,
    output logic [NDAC-1:0]      mosi_o,
    input  logic [NDAC-1:0]      miso_i,
    output logic                 busy_o,
    output logic                 loaded_o,
    output logic                 error_o,
    output logic [NCH/2-1:0]     pass_lo_o,
    output logic [NCH/2-1:0]     pass_hi_o
);
    hvl_ctl_t c_d, c_q;

    logic              load;
    logic              smp, adv, smp_ok, word_end;
    logic [NDAC-1:0]   nxt_b;
    logic [NDAC-1:0]   lane_ok;
    logic [WIDX_W-1:0] nw;
    logic [BIT_W-1:0]  nb;
    logic [REG_W-CODE_W-1:0] unused_hi;

    assign unused_hi = rd_data_i[REG_W-1:CODE_W];

    hvl_sclk_div #(.DIV(DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (c_q.st == ST_SHIFT),
        .sclk_o (sclk_o),
        .smp_o  (smp),
        .adv_o  (adv)
    );

    assign word_end = (c_q.bitp == BIT_W'(CODE_W - 1));
    assign smp_ok   = smp && (c_q.st == ST_SHIFT)
                      && !((c_q.word == '0) && word_end);

    always_comb begin
        if (c_q.bitp != '0) begin
            nw = c_q.word;
            nb = c_q.bitp - 1'b1;
        end else begin
            nw = c_q.word + 1'b1;
            nb = BIT_W'(CODE_W - 1);
        end
        for (int d = 0; d < NDAC; d++) begin
            if (int'(nw) < WPD) nxt_b[d] = c_q.mem[d * WPD + int'(nw)][nb];
            else                nxt_b[d] = 1'b0;
        end
    end

    for (genvar g = 0; g < NDAC; g++) begin : g_lane
        hvl_lane u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load),
            .first_i (HDR_WORD[CODE_W-1]),
            .adv_i   (adv),
            .nxt_i   (nxt_b[g]),
            .smp_i   (smp_ok),
            .end_i   (word_end),
            .fb_i    (miso_i[g]),
            .sdo_o   (mosi_o[g]),
            .ok_o    (lane_ok[g])
        );
    end

    always_comb begin
        rd_en_o   = (c_q.st == ST_FILL) && (c_q.fw != '0);
        rd_addr_o = '0;
        if (rd_en_o)
            rd_addr_o = ADDR_W'(int'(c_q.fd) * CPD + int'(c_q.fw) - 1);
    end

    always_comb begin
        c_d  = c_q;
        load = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    c_d.st     = ST_FILL;
                    c_d.busy   = 1'b1;
                    c_d.loaded = 1'b0;
                    c_d.err    = 1'b0;
                    c_d.pass   = '0;
                    c_d.hdr_ok = '1;
                    c_d.fd     = '0;
                    c_d.fw     = '0;
                end
            end
            ST_FILL: begin
                if (c_q.fw == '0)
                    c_d.mem[int'(c_q.fd) * WPD] = HDR_WORD;
                else
                    c_d.mem[int'(c_q.fd) * WPD + int'(c_q.fw)] = rd_data_i[CODE_W-1:0];
                if (c_q.fw == WIDX_W'(WPD - 1)) begin
                    c_d.fw = '0;
                    if (c_q.fd == DAC_W'(NDAC - 1)) begin
                        c_d.fd   = '0;
                        c_d.st   = ST_SHIFT;
                        c_d.word = '0;
                        c_d.bitp = BIT_W'(CODE_W - 1);
                        c_d.cs_n = 1'b0;
                        load     = 1'b1;
                    end else begin
                        c_d.fd = c_q.fd + 1'b1;
                    end
                end else begin
                    c_d.fw = c_q.fw + 1'b1;
                end
            end
            ST_SHIFT: begin
                if (smp_ok && word_end) begin
                    for (int d = 0; d < NDAC; d++) begin
                        if (c_q.word == WIDX_W'(1))
                            c_d.hdr_ok[d] = lane_ok[d];
                        else
                            c_d.pass[d * CPD + int'(c_q.word) - 2] = lane_ok[d];
                    end
                end
                if (adv) begin
                    if (c_q.word == WIDX_W'(WPD)) begin
                        c_d.st   = ST_DONE;
                        c_d.cs_n = 1'b1;
                    end else if (c_q.bitp == '0) begin
                        c_d.word = c_q.word + 1'b1;
                        c_d.bitp = BIT_W'(CODE_W - 1);
                    end else begin
                        c_d.bitp = c_q.bitp - 1'b1;
                    end
                end
            end
            ST_DONE: begin
                c_d.st     = ST_IDLE;
                c_d.busy   = 1'b0;
                c_d.loaded = 1'b1;
                c_d.err    = ~(&c_q.pass) | ~(&c_q.hdr_ok);
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.cs_n <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign cs_n_o    = {NDAC{c_q.cs_n}};
    assign busy_o    = c_q.busy;
    assign loaded_o  = c_q.loaded;
    assign error_o   = c_q.err;
    assign pass_lo_o = c_q.pass[NCH/2-1:0];
    assign pass_hi_o = c_q.pass[NCH-1:NCH/2];
endmodule

// File: rtl/hvl_dac_loader_chk.sv
module hvl_dac_loader_chk
    import hvl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              loaded_o,
    input logic              error_o,
    input logic              sclk_o,
    input logic [NDAC-1:0]   cs_n_o,
    input logic [NDAC-1:0]   mosi_o,
    input logic [NCH/2-1:0]  pass_lo_o,
    input logic [NCH/2-1:0]  pass_hi_o
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!sclk_o && (cs_n_o == '1)));

    // R1
    sel_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_o != '1) |-> busy_o);

    // R2
    start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(mosi_o));

    // R8
    end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> loaded_o);

    // R8
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loaded_o |-> !busy_o);

    // R9
    fresh_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (!loaded_o && !error_o && pass_lo_o == '0 && pass_hi_o == '0));
endmodule

bind hvl_dac_loader hvl_dac_loader_chk u_chk (.*);

// File: tb/tb_hvl_dac_loader.sv
module tb_hvl_dac_loader;
    import hvl_pkg::*;

    localparam int DIV = 8;
    localparam logic [CODE_W-1:0] HDR = 10'h2A5;
    localparam int TOTAL = 1 + NENT + NSLOT * DIV;
    localparam int WIN_LO = NENT;
    localparam int WIN_HI = NENT + NSLOT * DIV;

    logic clk = 1'b0;
    logic rst_n, start;
    logic rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [REG_W-1:0]  rd_data;
    logic sclk;
    logic [NDAC-1:0] cs_n, mosi, miso;
    logic busy, loaded, error_f;
    logic [NCH/2-1:0] pass_lo, pass_hi;

    logic [REG_W-1:0] bank [NCH];
    int flip_idx [NDAC];

    int vec = 0;
    int bad = 0;

    always #4 clk = ~clk;

    assign rd_data = bank[rd_addr];

    hvl_dac_loader #(.DIV(DIV), .HDR_WORD(HDR)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .sclk_o(sclk), .cs_n_o(cs_n), .mosi_o(mosi), .miso_i(miso),
        .busy_o(busy), .loaded_o(loaded), .error_o(error_f),
        .pass_lo_o(pass_lo), .pass_hi_o(pass_hi)
    );

    // Behavioural DAC models: capture on rising sclk, echo on falling sclk
    for (genvar g = 0; g < NDAC; g++) begin : g_dac
        logic cap, fb, sp;
        int rc;
        assign miso[g] = fb;
        always @(negedge clk) begin
            if (!rst_n) begin
                cap <= 1'b0; fb <= 1'b0; sp <= 1'b0; rc <= 0;
            end else begin
                sp <= sclk;
                if (cs_n[g]) rc <= 0;
                else if (sclk && !sp) begin
                    cap <= mosi[g];
                    rc  <= rc + 1;
                end else if (!sclk && sp) begin
                    fb <= cap ^ ((rc - 1) == flip_idx[g]);
                end
            end
        end
    end

    // Reference model
    logic mbusy, mloaded, merr;
    logic [NCH-1:0] mpass, fpass;
    logic ferr;
    int k;
    logic [CODE_W-1:0] snap [NCH];

    always @(posedge clk) begin
        if (!rst_n) begin
            mbusy <= 1'b0; mloaded <= 1'b0; merr <= 1'b0; mpass <= '0; k <= 0;
        end else if (!mbusy) begin
            if (start) begin
                logic [NCH-1:0] p;
                logic e;
                mbusy <= 1'b1; k <= 0;
                mloaded <= 1'b0; merr <= 1'b0; mpass <= '0;
                e = 1'b0;
                for (int c = 0; c < NCH; c++) begin
                    int d;
                    d = c / CPD;
                    snap[c] <= bank[c][CODE_W-1:0];
                    p[c] = !(flip_idx[d] >= 0 && flip_idx[d] / CODE_W == (c % CPD) + 1);
                    if (!p[c]) e = 1'b1;
                end
                for (int d = 0; d < NDAC; d++)
                    if (flip_idx[d] >= 0 && flip_idx[d] / CODE_W == 0) e = 1'b1;
                fpass <= p;
                ferr  <= e;
            end
        end else if (k == TOTAL - 1) begin
            mbusy <= 1'b0; mloaded <= 1'b1; merr <= ferr; mpass <= fpass;
        end else begin
            k <= k + 1;
        end
    end

    function automatic logic exp_mosi(input int d, input int m);
        int slot, w, bp;
        slot = m / DIV;
        w    = slot / CODE_W;
        bp   = CODE_W - 1 - (slot % CODE_W);
        if (w >= WPD) return 1'b0;
        if (w == 0)   return HDR[bp];
        return snap[d * CPD + w - 1][bp];
    endfunction

    logic checking = 1'b0;

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && checking) begin
            logic win;
            logic esclk;
            logic [NDAC-1:0] ecs, emosi;
            win = mbusy && (k >= WIN_LO) && (k < WIN_HI);
            esclk = win && (((k - WIN_LO) % DIV) >= DIV / 2);
            ecs = win ? '0 : '1;
            for (int d = 0; d < NDAC; d++)
                emosi[d] = win ? exp_mosi(d, k - WIN_LO) : 1'b0;
            vec++;
            if (busy !== mbusy) begin
                bad++;
                $display("FAIL %s busy: got %0b expected %0b (k=%0d)", mbusy ? "R2" : "R1", busy, mbusy, k);
            end
            if (sclk !== esclk) begin
                bad++;
                $display("FAIL %s sclk: got %0b expected %0b (k=%0d)", mbusy ? "R5" : "R1", sclk, esclk, k);
            end
            if (cs_n !== ecs) begin
                bad++;
                $display("FAIL %s cs_n: got %b expected %b (k=%0d)", mbusy ? "R5" : "R1", cs_n, ecs, k);
            end
            if (mosi !== emosi) begin
                bad++;
                $display("FAIL R3 R4 mosi: got %b expected %b (k=%0d)", mosi, emosi, k);
            end
            if (!mbusy || k == 0) begin
                if (loaded !== mloaded || error_f !== merr) begin
                    bad++;
                    $display("FAIL %s flags: got loaded=%0b err=%0b expected loaded=%0b err=%0b",
                             mbusy ? "R9" : "R8", loaded, error_f, mloaded, merr);
                end
                if ({pass_hi, pass_lo} !== mpass) begin
                    bad++;
                    $display("FAIL %s pass: got %h expected %h", mbusy ? "R9" : "R6 R7",
                             {pass_hi, pass_lo}, mpass);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vec++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_op(input bit mid);
        int bl;
        bl = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        forever begin
            if (busy) bl++;
            if (!mbusy) break;
            start = (mid && k == 100);
            if (mid && k == 300)
                for (int c = 0; c < NCH; c++) bank[c] = ~bank[c];
            @(negedge clk);
        end
        start = 1'b0;
        chk("R2 busy length", bl, TOTAL);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        for (int d = 0; d < NDAC; d++) flip_idx[d] = -1;
        for (int c = 0; c < NCH; c++) bank[c] = 16'(c * 29 + 7) | ((c % 3 == 0) ? 16'hFC00 : 16'h0);
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        checking = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 cs_n", cs_n, 4'hF);
        chk("R1 sclk", sclk, 0);
        chk("R1 pass", {pass_hi, pass_lo}, 0);
        repeat (8) @(negedge clk);

        // Clean load with ignored mid-run start and post-fill bank change (R2, R3)
        run_op(1'b1);
        chk("R6 R7 all pass", {pass_hi, pass_lo}, 32'hFFFF_FFFF);
        chk("R8 no error", error_f, 0);
        chk("R8 loaded", loaded, 1);

        // Echo faults on last bit of ch10 and first bit of ch31
        for (int c = 0; c < NCH; c++) bank[c] = (c % 2 == 0) ? 16'h03FF : 16'hFC00;
        flip_idx[1] = 3 * CODE_W + 9;
        flip_idx[3] = 8 * CODE_W;
        run_op(1'b0);
        chk("R7 pass_lo", pass_lo, 16'hFBFF);
        chk("R7 pass_hi", pass_hi, 16'h7FFF);
        chk("R8 error on mismatch", error_f, 1);

        // Control word fault only (R4, R8)
        flip_idx[1] = -1;
        flip_idx[3] = -1;
        flip_idx[2] = 5;
        for (int c = 0; c < NCH; c++) bank[c] = 16'((c * 37 + 11) ^ 16'hA400);
        run_op(1'b0);
        chk("R6 pass with header fault", {pass_hi, pass_lo}, 32'hFFFF_FFFF);
        chk("R8 header error", error_f, 1);

        // Clean again: flags cleared and results fresh (R9)
        flip_idx[2] = -1;
        run_op(1'b0);
        chk("R9 error cleared", error_f, 0);
        chk("R9 pass refreshed", {pass_hi, pass_lo}, 32'hFFFF_FFFF);

        checking = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL R2 watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule